// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of an auto-zeroing dual-slope analog-to-digital converter. It steps through a fixed six-phase conversion cycle. It drives the analog switch enables for each phase and times the variable phases from a single comparator input. It produces a counted result, a range flag and an end-of-conversion pulse. The analog integrator and comparator sit outside the block.

Zero correction is digital. Each cycle has a short phase in which the integrator ramps to the comparator threshold. The clocks that ramp takes are stored as an offset count. Later in the cycle, that count is replayed as extra reference de-integration time ahead of the measured ramp. The result is the clock count from the start of the final de-integration phase to the comparator trip.

A display-update input decides whether the output latches take the new reading. A rising edge on it counts only while the cycle is still in the auto-zero, offset or input-integrate phases. All storage uses a synchronous active-high reset, and reset restarts the cycle at its first phase.

Top module: `dslope_seq`

## Requirements
- R1: The phases run in the order A (auto-zero, AZ_CLKS clocks), O (offset measure), B (auto-zero, AZ_CLKS clocks), I (input integrate, INT_CLKS clocks), P (offset replay), D (de-integrate, DEINT_CLKS clocks), then back to A. Exactly one enable group is high in every clock: `az_charge` and `int_short` in A and B, `ofs_measure` in O, `integ_input` in I, and `deint_ref` in P and D.
- R2: Phase O ends after the first clock in which `cmp` is high. If that clock is the k-th clock of the phase (counting from 0), then O lasted k+1 clocks and the offset count is k. If `cmp` stays low, O ends after OFS_MAX clocks and stores OFS_MAX-1.
- R3: Phase P lasts exactly the stored offset count. If that count is 0, phase D follows phase I directly.
- R4: Phase D always lasts DEINT_CLKS clocks. Its raw count is the index (from 0) of the first clock in D with `cmp` high. If no such clock occurs, the raw count saturates at DEINT_CLKS-1.
- R5: `range_ok` is low after a load whose phase D saw no comparator trip, or whose raw count exceeds FS_MAX. It is high after any other load.
- R6: The level of `cmp` in the last clock of phase I is the measured polarity (1 = positive). `pol_sel` takes that value at the end of the cycle. `res_pos` reports it together with a loaded result. Both are 1 after reset.
- R7: A rising edge on `disp_upd` means low at one clock edge and high at the next. If such an edge is seen while the phase is A, O, B or I, then at the end of that cycle `result`, `range_ok` and `res_pos` update and `load` is high for one clock. Otherwise all three hold and `load` stays low. Edges during P or D have no effect.
- R8: `eoc` is high only during the first half of the clock period that follows the last clock of phase D, and it is low at all other times.
- R9: While `rst` is high at a clock edge, the sequencer returns to the first clock of phase A. The stored offset, `result` and `load` go to 0, `range_ok`, `pol_sel` and `res_pos` go to 1, and no update is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, restarts the cycle |
| cmp | input | 1 | Comparator output, high when the integrator has crossed the threshold |
| disp_upd | input | 1 | Display-update request, rising edge arms a latch load |
| az_charge | output | 1 | Offset capacitor charge switch enable |
| int_short | output | 1 | Integrator short switch enable |
| ofs_measure | output | 1 | Offset measurement ramp enable |
| integ_input | output | 1 | Unknown input integration enable |
| deint_ref | output | 1 | Reference de-integration enable |
| pol_sel | output | 1 | Polarity used for the switch configuration this cycle |
| result | output | RES_W | Latched conversion count |
| res_pos | output | 1 | Latched polarity of the result |
| range_ok | output | 1 | High unless the latched reading is out of range |
| load | output | 1 | One-clock strobe when the output latches update |
| eoc | output | 1 | Half-clock end-of-conversion pulse |

## Verification
The cases hardest to reach from the ports depend on the comparator trip falling on exact clocks inside a phase of variable length. These are an offset measurement that saturates, a zero offset that removes the replay phase, a trip on the very first clock of de-integration, and an update edge that arrives only after ramp-down has begun. The bench tracks the phase on its own and drives `cmp` and `disp_upd` from a scenario table indexed by that phase and its clock index, so each corner falls on a chosen clock. One scenario also asserts reset in the middle of input integration and checks that the cycle restarts cleanly.

// File: rtl/dsq_pkg.sv
`timescale 1ns/1ps
package dsq_pkg;

  typedef enum logic [2:0] {
    PH_AZ_A   = 3'd1,
    PH_OFS    = 3'd2,
    PH_AZ_B   = 3'd3,
    PH_INTEG  = 3'd4,
    PH_REPLAY = 3'd5,
    PH_DEINT  = 3'd6
  } phase_e;

  function automatic int dsq_max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/dsq_phase_ctl.sv
`timescale 1ns/1ps
module dsq_phase_ctl
  import dsq_pkg::*;
#(
  parameter int AZ_CLKS    = 4000,
  parameter int OFS_MAX    = 800,
  parameter int INT_CLKS   = 2000,
  parameter int DEINT_CLKS = 4000,
  parameter int CNT_W      = 12,
  parameter int OFS_W      = 10
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp,
  input  logic [OFS_W-1:0] ofs_q,
  output phase_e           ph,
  output logic [CNT_W-1:0] cnt,
  output logic             ofs_done,
  output logic             integ_last,
  output logic             cycle_end,
  output logic             az_en,
  output logic             ofs_en,
  output logic             integ_en,
  output logic             deint_en
);

  localparam logic [CNT_W-1:0] AZ_LAST    = CNT_W'(AZ_CLKS - 1);
  localparam logic [CNT_W-1:0] OFS_LAST   = CNT_W'(OFS_MAX - 1);
  localparam logic [CNT_W-1:0] INT_LAST   = CNT_W'(INT_CLKS - 1);
  localparam logic [CNT_W-1:0] DEINT_LAST = CNT_W'(DEINT_CLKS - 1);

  phase_e           ph_nxt;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] ofs_ext;
  logic [CNT_W-1:0] replay_last;

  assign ofs_ext     = CNT_W'(ofs_q);
  assign replay_last = ofs_ext - CNT_W'(1);

  assign ofs_done   = (ph == PH_OFS) && (cmp || (cnt == OFS_LAST));
  assign integ_last = (ph == PH_INTEG) && (cnt == INT_LAST);
  assign cycle_end  = (ph == PH_DEINT) && (cnt == DEINT_LAST);

  always_comb begin
    ph_nxt  = ph;
    cnt_nxt = cnt + CNT_W'(1);
    case (ph)
      PH_AZ_A: if (cnt == AZ_LAST) begin
        ph_nxt  = PH_OFS;
        cnt_nxt = '0;
      end
      PH_OFS: if (ofs_done) begin
        ph_nxt  = PH_AZ_B;
        cnt_nxt = '0;
      end
      PH_AZ_B: if (cnt == AZ_LAST) begin
        ph_nxt  = PH_INTEG;
        cnt_nxt = '0;
      end
      PH_INTEG: if (integ_last) begin
        ph_nxt  = (ofs_q == '0) ? PH_DEINT : PH_REPLAY;
        cnt_nxt = '0;
      end
      PH_REPLAY: if (cnt == replay_last) begin
        ph_nxt  = PH_DEINT;
        cnt_nxt = '0;
      end
      PH_DEINT: if (cycle_end) begin
        ph_nxt  = PH_AZ_A;
        cnt_nxt = '0;
      end
      default: begin
        ph_nxt  = PH_AZ_A;
        cnt_nxt = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_AZ_A;
      cnt      <= '0;
      az_en    <= 1'b1;
      ofs_en   <= 1'b0;
      integ_en <= 1'b0;
      deint_en <= 1'b0;
    end else begin
      ph       <= ph_nxt;
      cnt      <= cnt_nxt;
      az_en    <= (ph_nxt == PH_AZ_A) || (ph_nxt == PH_AZ_B);
      ofs_en   <= (ph_nxt == PH_OFS);
      integ_en <= (ph_nxt == PH_INTEG);
      deint_en <= (ph_nxt == PH_REPLAY) || (ph_nxt == PH_DEINT);
    end
  end

  AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $countones({az_en, ofs_en, integ_en, deint_en}) == 1); // R1
  AST_AZ_TO_OFS: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_AZ_A && cnt == AZ_LAST) |=> (ph == PH_OFS && ofs_en)); // R1
  AST_P2_BOUND: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_OFS) |-> (cnt <= OFS_LAST)); // R2
  AST_P5_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_REPLAY) |-> (ofs_q != '0 && ofs_ext > cnt)); // R3
  AST_RESET_P1: assert property (@(posedge clk)
    rst |=> (ph == PH_AZ_A && cnt == '0 && az_en)); // R9

endmodule

// File: rtl/dsq_offset_store.sv
`timescale 1ns/1ps
module dsq_offset_store #(
  parameter int OFS_W = 10
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             ofs_done,
  input  logic [OFS_W-1:0] cnt,
  output logic [OFS_W-1:0] ofs_q
);

  always_ff @(posedge clk) begin
    if (rst)           ofs_q <= '0;
    else if (ofs_done) ofs_q <= cnt;
  end

  AST_OFS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ofs_done |=> $stable(ofs_q)); // R3

endmodule

// File: rtl/dsq_result_unit.sv
`timescale 1ns/1ps
module dsq_result_unit
  import dsq_pkg::*;
#(
  parameter int DEINT_CLKS = 4000,
  parameter int FS_MAX     = 1999,
  parameter int RES_W      = 12
)(
  input  logic             clk,
  input  logic             rst,
  input  phase_e           ph,
  input  logic [RES_W-1:0] cnt,
  input  logic             cmp,
  input  logic             cycle_end,
  input  logic             integ_last,
  input  logic             upd,
  output logic             pol_sel,
  output logic [RES_W-1:0] result,
  output logic             res_pos,
  output logic             range_ok,
  output logic             load
);

  localparam logic [RES_W-1:0] SAT_VAL = RES_W'(DEINT_CLKS - 1);
  localparam logic [RES_W:0]   FS_LIM  = (RES_W+1)'(FS_MAX);

  logic             upd_q;
  logic             armed;
  logic             tripped;
  logic [RES_W-1:0] trip_cnt;
  logic             pol_meas;
  logic             hit;
  logic [RES_W-1:0] raw;
  logic             over;
  logic             rise;
  logic             pre_ramp;

  assign rise     = upd && !upd_q;
  assign pre_ramp = (ph == PH_AZ_A) || (ph == PH_OFS) ||
                    (ph == PH_AZ_B) || (ph == PH_INTEG);
  assign hit      = tripped || cmp;
  assign raw      = tripped ? trip_cnt : (cmp ? cnt : SAT_VAL);
  assign over     = !hit || ({1'b0, raw} > FS_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_q    <= 1'b1;
      armed    <= 1'b0;
      tripped  <= 1'b0;
      trip_cnt <= '0;
      pol_meas <= 1'b1;
      pol_sel  <= 1'b1;
      result   <= '0;
      res_pos  <= 1'b1;
      range_ok <= 1'b1;
      load     <= 1'b0;
    end else begin
      upd_q <= upd;
      load  <= 1'b0;
      if (integ_last) pol_meas <= cmp;
      if (ph == PH_DEINT) begin
        if (cmp && !tripped) begin
          tripped  <= 1'b1;
          trip_cnt <= cnt;
        end
      end else begin
        tripped <= 1'b0;
      end
      if (cycle_end) begin
        armed   <= 1'b0;
        pol_sel <= pol_meas;
        if (armed) begin
          load     <= 1'b1;
          result   <= raw;
          range_ok <= !over;
          res_pos  <= pol_meas;
        end
      end else if (rise && pre_ramp) begin
        armed <= 1'b1;
      end
    end
  end

  AST_LOAD_AT_END: assert property (@(posedge clk) disable iff (rst)
    load |-> $past(cycle_end)); // R7
  AST_RANGE_ON_FS: assert property (@(posedge clk) disable iff (rst)
    (load && ({1'b0, result} > FS_LIM)) |-> !range_ok); // R5
  AST_POL_STEADY: assert property (@(posedge clk) disable iff (rst)
    !cycle_end |=> $stable(pol_sel)); // R6

endmodule

// File: rtl/dsq_eoc_gen.sv
`timescale 1ns/1ps
module dsq_eoc_gen (
  input  logic clk,
  input  logic rst,
  input  logic cycle_end,
  output logic eoc
);

  logic eoc_r;
  logic eoc_h;

  always_ff @(posedge clk) begin
    if (rst) eoc_r <= 1'b0;
    else     eoc_r <= cycle_end;
  end

  always_ff @(negedge clk) begin
    if (rst) eoc_h <= 1'b0;
    else     eoc_h <= eoc_r;
  end

  assign eoc = eoc_r && !eoc_h;

  AST_EOC_SPACED: assert property (@(posedge clk) disable iff (rst)
    eoc_r |=> !eoc_r); // R8

endmodule

// File: rtl/dslope_seq.sv
`timescale 1ns/1ps
module dslope_seq
  import dsq_pkg::*;
#(
  parameter int AZ_CLKS    = 4000,
  parameter int OFS_MAX    = 800,
  parameter int INT_CLKS   = 2000,
  parameter int DEINT_CLKS = 4000,
  parameter int FS_MAX     = 1999,
  parameter int CNT_W      = $clog2(dsq_max4(AZ_CLKS, OFS_MAX, INT_CLKS, DEINT_CLKS)),
  parameter int RES_W      = $clog2(DEINT_CLKS)
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp,
  input  logic             disp_upd,
  output logic             az_charge,
  output logic             int_short,
  output logic             ofs_measure,
  output logic             integ_input,
  output logic             deint_ref,
  output logic             pol_sel,
  output logic [RES_W-1:0] result,
  output logic             res_pos,
  output logic             range_ok,
  output logic             load,
  output logic             eoc
);

  localparam int OFS_W = $clog2(OFS_MAX);

  phase_e           ph;
  logic [CNT_W-1:0] cnt;
  logic [OFS_W-1:0] ofs_q;
  logic             ofs_done;
  logic             integ_last;
  logic             cycle_end;
  logic             az_en;

  dsq_phase_ctl #(
    .AZ_CLKS(AZ_CLKS), .OFS_MAX(OFS_MAX), .INT_CLKS(INT_CLKS),
    .DEINT_CLKS(DEINT_CLKS), .CNT_W(CNT_W), .OFS_W(OFS_W)
  ) u_ctl (
    .clk(clk), .rst(rst), .cmp(cmp), .ofs_q(ofs_q),
    .ph(ph), .cnt(cnt), .ofs_done(ofs_done), .integ_last(integ_last),
    .cycle_end(cycle_end), .az_en(az_en), .ofs_en(ofs_measure),
    .integ_en(integ_input), .deint_en(deint_ref)
  );

  dsq_offset_store #(.OFS_W(OFS_W)) u_ofs (
    .clk(clk), .rst(rst), .ofs_done(ofs_done),
    .cnt(cnt[OFS_W-1:0]), .ofs_q(ofs_q)
  );

  dsq_result_unit #(
    .DEINT_CLKS(DEINT_CLKS), .FS_MAX(FS_MAX), .RES_W(RES_W)
  ) u_res (
    .clk(clk), .rst(rst), .ph(ph), .cnt(cnt[RES_W-1:0]), .cmp(cmp),
    .cycle_end(cycle_end), .integ_last(integ_last), .upd(disp_upd),
    .pol_sel(pol_sel), .result(result), .res_pos(res_pos),
    .range_ok(range_ok), .load(load)
  );

  dsq_eoc_gen u_eoc (
    .clk(clk), .rst(rst), .cycle_end(cycle_end), .eoc(eoc)
  );

  assign az_charge = az_en;
  assign int_short = az_en;

endmodule

// File: tb/tb_dslope_seq.sv
`timescale 1ns/1ps
module tb_dslope_seq;

  localparam int AZ = 20;
  localparam int OM = 12;
  localparam int IN = 40;
  localparam int DE = 48;
  localparam int FS = 39;
  localparam int RW = 6;
  localparam int NSCEN = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp = 1'b0;
  logic disp_upd = 1'b0;
  logic az_charge, int_short, ofs_measure, integ_input, deint_ref;
  logic pol_sel, res_pos, range_ok, load, eoc;
  logic [RW-1:0] result;

  always #10 clk = ~clk;

  dslope_seq #(
    .AZ_CLKS(AZ), .OFS_MAX(OM), .INT_CLKS(IN), .DEINT_CLKS(DE), .FS_MAX(FS)
  ) dut (
    .clk(clk), .rst(rst), .cmp(cmp), .disp_upd(disp_upd),
    .az_charge(az_charge), .int_short(int_short), .ofs_measure(ofs_measure),
    .integ_input(integ_input), .deint_ref(deint_ref), .pol_sel(pol_sel),
    .result(result), .res_pos(res_pos), .range_ok(range_ok),
    .load(load), .eoc(eoc)
  );

  // scenario table: offset trip clock, input sign, de-integrate trip clock, update phase
  int s_ofs [NSCEN] = '{3, -1, 0, 5, 7, 2, 11, 4};
  int s_sgn [NSCEN] = '{1, 0, 1, 0, 1, 1, 0, 1};
  int s_trp [NSCEN] = '{10, 39, 40, -1, 0, 25, 39, 20};
  int s_upd [NSCEN] = '{1, 0, 4, 3, 6, 5, 2, 1};

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  int m_ph, m_tick, m_ofs, m_trip, scen;
  int m_armed, m_updq, m_polm, m_pols, m_res, m_rok, m_rpos, m_load, m_eoc;
  bit m_rstcyc;

  task automatic chk(input string tag, input string what, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic model_step();
    int nph, ntick, hit;
    bit rise, cend;
    if (rst) begin
      m_ph = 1; m_tick = 0; m_ofs = 0; m_trip = -1; m_armed = 0; m_updq = 1;
      m_polm = 1; m_pols = 1; m_res = 0; m_rok = 1; m_rpos = 1; m_load = 0; m_eoc = 0;
      m_rstcyc = 1'b1;
      return;
    end
    m_rstcyc = 1'b0;
    rise = disp_upd && (m_updq == 0);
    m_updq = disp_upd;
    cend = (m_ph == 6) && (m_tick == DE - 1);
    m_eoc = cend;
    m_load = 0;
    if (m_ph == 4 && m_tick == IN - 1) m_polm = cmp;
    if (cend) begin
      hit = (m_trip >= 0) ? m_trip : (cmp ? m_tick : -1);
      m_pols = m_polm;
      if (m_armed != 0) begin
        m_load = 1;
        m_res  = (hit >= 0) ? hit : DE - 1;
        m_rok  = (hit >= 0 && hit <= FS) ? 1 : 0;
        m_rpos = m_polm;
      end
      m_armed = 0;
    end else if (rise && m_ph <= 4) begin
      m_armed = 1;
    end
    if (m_ph == 6) begin
      if (cmp && m_trip < 0) m_trip = m_tick;
    end else begin
      m_trip = -1;
    end
    nph = m_ph;
    case (m_ph)
      1, 3: if (m_tick == AZ - 1) nph = m_ph + 1;
      2: if (cmp || m_tick == OM - 1) begin m_ofs = m_tick; nph = 3; end
      4: if (m_tick == IN - 1) nph = (m_ofs == 0) ? 6 : 5;
      5: if (m_tick == m_ofs - 1) nph = 6;
      default: if (cend) begin nph = 1; scen++; end
    endcase
    ntick = (nph != m_ph) ? 0 : m_tick + 1;
    m_ph = nph;
    m_tick = ntick;
  endtask

  task automatic drive_inputs();
    int sc;
    sc = (scen < NSCEN) ? scen : NSCEN - 1;
    case (m_ph)
      2: cmp = (s_ofs[sc] >= 0) && (m_tick >= s_ofs[sc]);
      4: cmp = (m_tick == IN - 1) ? s_sgn[sc][0] : 1'b0;
      6: cmp = (s_trp[sc] >= 0) && (m_tick >= s_trp[sc]);
      default: cmp = 1'b0;
    endcase
    disp_upd = (m_ph == s_upd[sc]) && (m_tick >= 1);
  endtask

  task automatic compare_outputs();
    string te, t2, t3, t4, t5, t6, t7;
    te = m_rstcyc ? "R9" : "R1";
    t2 = m_rstcyc ? "R9" : "R2";
    t3 = m_rstcyc ? "R9" : "R3";
    t4 = m_rstcyc ? "R9" : "R4";
    t5 = m_rstcyc ? "R9" : "R5";
    t6 = m_rstcyc ? "R9" : "R6";
    t7 = m_rstcyc ? "R9" : "R7";
    chk(te, "az_charge", int'(az_charge), (m_ph == 1 || m_ph == 3) ? 1 : 0);
    chk(te, "int_short", int'(int_short), (m_ph == 1 || m_ph == 3) ? 1 : 0);
    chk(t2, "ofs_measure", int'(ofs_measure), (m_ph == 2) ? 1 : 0);
    chk(te, "integ_input", int'(integ_input), (m_ph == 4) ? 1 : 0);
    chk(t3, "deint_ref", int'(deint_ref), (m_ph == 5 || m_ph == 6) ? 1 : 0);
    chk(t6, "pol_sel", int'(pol_sel), m_pols);
    chk(t4, "result", int'(result), m_res);
    chk(t6, "res_pos", int'(res_pos), m_rpos);
    chk(t5, "range_ok", int'(range_ok), m_rok);
    chk(t7, "load", int'(load), m_load);
    chk(m_rstcyc ? "R9" : "R8", "eoc_first_half", int'(eoc), m_eoc);
  endtask

  initial begin
    int rst_hold;
    bit did_rst;
    rst_hold = 0;
    did_rst = 1'b0;
    scen = 0;
    for (int cyc = 0; cyc < 20000 && scen < NSCEN; cyc++) begin
      @(posedge clk);
      model_step();
      #1;
      if (cyc == 3) rst = 1'b0;
      if (rst_hold > 0) begin
        rst_hold--;
        if (rst_hold == 0) rst = 1'b0;
      end else if (scen == NSCEN - 1 && !did_rst && m_ph == 4 && m_tick == 10) begin
        rst = 1'b1;   // mid-cycle reset during input integration (R9)
        rst_hold = 2;
        did_rst = 1'b1;
      end
      drive_inputs();
      #4;
      compare_outputs();
      #10;
      chk("R8", "eoc_second_half", int'(eoc), 0);
    end
    chk("R1", "all_scenarios_done", scen, NSCEN);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL R1 watchdog: got 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
      $finish;
    end
  end

endmodule